// File: doc/BRIEF.md
# Per-Link Frame Gap Regulator

This block decides when frames may start on each of a small number of one-way logical links. Every link has its own minimum spacing between frame starts. The spacing is a power of two in milliseconds, from 1 ms to 128 ms. Every link also has its own cap on frame length. A link's single source presents a request together with the frame's byte length and holds it. In the same cycle, the block answers with a grant that carries the link index, or with a reject pulse for that link. The source drops the request after either answer.

A free-running 1 ms tick input paces one down-counter per link. A grant loads that link's counter with its spacing in ticks. The link becomes eligible again once the counter has reached zero. When several eligible links compete in the same cycle, a round-robin arbiter grants one of them. The arbiter starts its search at the link after the one most recently granted. Frame data, the MAC and jitter accounting sit outside this block.

Top module: `gap_regulator`

## Requirements
- R1: After reset every link is eligible. With no request present, `grant_valid` and every `reject` bit are 0. The first legal request on any link is granted in the cycle it is presented.
- R2: A request on a link whose counter is zero, and whose length is within the limit, drives `grant_valid` high with `grant_link` equal to that link in the same cycle.
- R3: After a grant, the link is not granted again until 2^g ticks have been sampled in cycles after the grant cycle. It is grantable in the first cycle after the edge that samples the 2^g-th tick.
- R4: The gap code `g` is 3 bits and equals log2 of the spacing in milliseconds. Code 0 gives 1 tick, code 7 gives 128 ticks.
- R5: A request whose length exceeds the link's effective limit raises that link's `reject` bit in the same cycle. Such a request is never granted and leaves the link's counter as it was. A legal request on another link can be granted in that same cycle.
- R6: The effective limit is the configured maximum, clamped to 1518 bytes. With a configured maximum of 2047, a length of 1519 is rejected and a length of 1518 is granted.
- R7: A length equal to the effective limit is granted.
- R8: When several links are eligible, the grant goes to the first eligible link found by searching upward from the link after the most recently granted one, wrapping around. After reset the search starts at link 0.
- R9: A tick in the same cycle as a grant does not count toward that grant's spacing.
- R10: Changing a link's gap code while its counter is running does not alter the running count. The new code applies from that link's next grant.
- R11: At most one grant is issued per cycle. When `grant_valid` is high, `grant_link` names a link that is requesting in that cycle and is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| req_valid | input | NUM_LINKS | Per-link request, held until granted or rejected |
| req_len | input | NUM_LINKS*LEN_W | Per-link frame length in bytes, link i at bits [i*LEN_W +: LEN_W] |
| cfg_gap | input | NUM_LINKS*3 | Per-link gap code (log2 of ms), link i at bits [i*3 +: 3] |
| cfg_max_len | input | NUM_LINKS*LEN_W | Per-link maximum frame length in bytes |
| grant_valid | output | 1 | A frame start is granted this cycle |
| grant_link | output | IDX_W | Index of the granted link |
| reject | output | NUM_LINKS | Per-link oversize reject pulse |

## Verification
A corrupted gap counter shows up at the ports as a grant that comes some whole number of ticks too early or too late. It becomes visible at the first request made after the expected spacing, so the bench probes both the last blocked tick and the first allowed one. A wrong round-robin pointer shows as the wrong `grant_link` on the first contended cycle. A broken length compare shows immediately, as a `reject` bit or a grant on the boundary lengths 512/513 and 1518/1519.

// File: rtl/gap_reg_pkg.sv
// Package: shared constants and helpers for the per-link gap regulator.
// Assumes spacing codes are log2 of milliseconds and the length ceiling is
// fixed by the network's largest legal frame.
package gap_reg_pkg;
    localparam int GAP_CODE_W   = 3;
    localparam int MAX_GAP_LOG2 = (1 << GAP_CODE_W) - 1;
    localparam int CNT_W        = MAX_GAP_LOG2 + 1;
    localparam int LEN_CEIL     = 1518;

    // Number of ticks that a gap code stands for.
    function automatic logic [CNT_W-1:0] gap_ticks(input logic [GAP_CODE_W-1:0] code);
        return CNT_W'(1) << code;
    endfunction
endpackage

// File: rtl/gap_timer.sv
// Module: gap_timer
// One link's spacing counter. A grant loads it with 2^code ticks and each
// ms tick after that counts it down to zero. Zero means the link may start
// a frame. A load in the same cycle as a tick wins, so that tick is not counted.
// Assumes: load is asserted only while idle is high.
module gap_timer
    import gap_reg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  load,
    input  logic [GAP_CODE_W-1:0] gap_code,
    output logic                  idle
);
    logic [CNT_W-1:0] cnt_q;

    // Counter: load on grant, otherwise count ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= gap_ticks(gap_code);
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign idle = (cnt_q == '0);

    // R3
    rearm_only_by_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && $past(cnt_q) == '0) |-> $past(load));

    // R10
    steady_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) != '0 && !$past(load)) |->
        (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/len_limit.sv
// Module: len_limit
// Oversize check for one link. The configured maximum is clamped to the
// ceiling, and a length strictly above the clamped value is oversize.
// Assumes: LEN_W is wide enough to hold the ceiling.
module len_limit
    import gap_reg_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic [LEN_W-1:0] len,
    input  logic [LEN_W-1:0] max_cfg,
    output logic             over
);
    localparam logic [LEN_W-1:0] CEIL_V = LEN_W'(LEN_CEIL);

    logic [LEN_W-1:0] eff_max;

    // Clamp the configured limit, then compare.
    always_comb begin
        eff_max = (max_cfg > CEIL_V) ? CEIL_V : max_cfg;
        over    = (len > eff_max);
    end
endmodule

// File: rtl/rr_arbiter.sv
// Module: rr_arbiter
// Round-robin pick of one eligible link per cycle. The search starts just
// after the last granted index and wraps. The pointer resets so that index 0
// is searched first.
// Assumes: N >= 1, IDX_W can hold N-1.
module rr_arbiter #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     elig,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_idx
);
    logic [IDX_W-1:0] last_q;

    // Scan from farthest to nearest so the nearest eligible index wins.
    always_comb begin
        int pos;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int off = N; off >= 1; off--) begin
            pos = (int'(last_q) + off) % N;
            if (elig[IDX_W'(pos)]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IDX_W'(pos);
            end
        end
    end

    // Pointer: remember the most recent winner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= IDX_W'(N - 1);
        else if (gnt_valid)
            last_q <= gnt_idx;
    end

    // R11
    winner_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> elig[gnt_idx]);
endmodule

// File: rtl/gap_regulator.sv
// Module: gap_regulator (top)
// Per-link frame start regulator. Each link has a spacing counter and an
// oversize check. Eligible requests go to a round-robin arbiter. Grant and
// reject answer the held request in the same cycle.
// Assumes: one source per link, which holds its request until it sees a
// grant or reject, then drops it.
module gap_regulator
    import gap_reg_pkg::*;
#(
    parameter  int NUM_LINKS = 4,
    parameter  int LEN_W     = 11,
    localparam int IDX_W     = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ms_tick,
    input  logic [NUM_LINKS-1:0]            req_valid,
    input  logic [NUM_LINKS*LEN_W-1:0]      req_len,
    input  logic [NUM_LINKS*GAP_CODE_W-1:0] cfg_gap,
    input  logic [NUM_LINKS*LEN_W-1:0]      cfg_max_len,
    output logic                            grant_valid,
    output logic [IDX_W-1:0]                grant_link,
    output logic [NUM_LINKS-1:0]            reject
);
    logic [NUM_LINKS-1:0] over;
    logic [NUM_LINKS-1:0] idle;
    logic [NUM_LINKS-1:0] elig;
    logic [NUM_LINKS-1:0] load;

    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
        len_limit #(.LEN_W(LEN_W)) u_len (
            .len     (req_len[i*LEN_W +: LEN_W]),
            .max_cfg (cfg_max_len[i*LEN_W +: LEN_W]),
            .over    (over[i])
        );

        gap_timer u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (ms_tick),
            .load     (load[i]),
            .gap_code (cfg_gap[i*GAP_CODE_W +: GAP_CODE_W]),
            .idle     (idle[i])
        );

        // Per-link qualification of the request.
        always_comb begin
            elig[i]   = req_valid[i] && !over[i] && idle[i];
            reject[i] = req_valid[i] && over[i];
            load[i]   = grant_valid && (grant_link == IDX_W'(i));
        end
    end

    rr_arbiter #(.N(NUM_LINKS), .IDX_W(IDX_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (elig),
        .gnt_valid (grant_valid),
        .gnt_idx   (grant_link)
    );

    // R5
    no_grant_on_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> !reject[grant_link]);

    // R3
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !(grant_valid && grant_link == $past(grant_link)));

    // R11
    grant_has_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> req_valid[grant_link]);
endmodule

// File: tb/sim_gap_regulator.sv
// Directed bench for gap_regulator. Inputs change just after a falling edge.
// Outputs (combinational on held state) are checked 1 ns later, before the
// next rising edge.
module sim_gap_regulator;
    localparam int NL = 4;
    localparam int LW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ms_tick = 1'b0;
    logic [NL-1:0] req_valid = '0;
    logic [NL*LW-1:0] req_len = '0;
    logic [NL*3-1:0]  cfg_gap = '0;
    logic [NL*LW-1:0] cfg_max_len = '0;
    logic          grant_valid;
    logic [1:0]    grant_link;
    logic [NL-1:0] reject;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gap_regulator #(.NUM_LINKS(NL), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .req_valid(req_valid), .req_len(req_len),
        .cfg_gap(cfg_gap), .cfg_max_len(cfg_max_len),
        .grant_valid(grant_valid), .grant_link(grant_link), .reject(reject)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            ms_tick = 1'b1;
            @(negedge clk);
        end
        ms_tick = 1'b0;
    endtask

    // Present one request for one cycle and check grant and reject.
    task automatic try_req(input int link, input int length, input bit exp_g,
                           input bit exp_r, input string tag);
        req_len[link*LW +: LW] = LW'(length);
        req_valid = NL'(1) << link;
        #1;
        check_eq({tag, " grant_valid"}, int'(grant_valid), int'(exp_g));
        if (exp_g) check_eq({tag, " grant_link"}, int'(grant_link), link);
        check_eq({tag, " reject"}, int'(reject[link]), int'(exp_r));
        @(negedge clk);
        req_valid = '0;
    endtask

    task automatic t_reset;
        #1;
        check_eq("R1 idle grant", int'(grant_valid), 0);
        check_eq("R1 idle reject", int'(reject), 0);
        @(negedge clk);
        try_req(0, 64, 1, 0, "R1 first request");
        tick_n(1);
        try_req(2, 200, 1, 0, "R2 grant on idle link");
        tick_n(1);
    endtask

    task automatic t_gap_basic;
        cfg_gap[0*3 +: 3] = 3'd2;
        try_req(0, 100, 1, 0, "R3 initial grant");
        tick_n(3);
        try_req(0, 100, 0, 0, "R3 blocked after 3 of 4 ticks");
        tick_n(1);
        try_req(0, 100, 1, 0, "R3 grant after 4 ticks");
        tick_n(4);
    endtask

    task automatic t_gap_extremes;
        cfg_gap[1*3 +: 3] = 3'd7;
        try_req(1, 300, 1, 0, "R4 code7 grant");
        tick_n(127);
        try_req(1, 300, 0, 0, "R4 code7 blocked at 127");
        tick_n(1);
        try_req(1, 300, 1, 0, "R4 code7 grant at 128");
        tick_n(128);
        cfg_gap[1*3 +: 3] = 3'd0;
        try_req(1, 300, 1, 0, "R4 code0 grant");
        try_req(1, 300, 0, 0, "R4 code0 blocked before tick");
        tick_n(1);
        try_req(1, 300, 1, 0, "R4 code0 grant after 1 tick");
        tick_n(1);
    endtask

    task automatic t_tick_collide;
        cfg_gap[0*3 +: 3] = 3'd1;
        req_len[0 +: LW] = LW'(80);
        req_valid = 4'b0001;
        ms_tick = 1'b1;
        #1;
        check_eq("R9 grant with tick", int'(grant_valid), 1);
        @(negedge clk);
        req_valid = '0;
        ms_tick = 1'b0;
        tick_n(1);
        try_req(0, 80, 0, 0, "R9 same-cycle tick not counted");
        tick_n(1);
        try_req(0, 80, 1, 0, "R9 grant after 2 later ticks");
        tick_n(2);
    endtask

    task automatic t_cfg_change;
        cfg_gap[2*3 +: 3] = 3'd3;
        try_req(2, 400, 1, 0, "R10 grant code3");
        cfg_gap[2*3 +: 3] = 3'd0;
        tick_n(7);
        try_req(2, 400, 0, 0, "R10 running count kept");
        tick_n(1);
        try_req(2, 400, 1, 0, "R10 grant after 8 ticks");
        tick_n(1);
        try_req(2, 400, 1, 0, "R10 new code used");
        tick_n(1);
    endtask

    task automatic t_length;
        cfg_max_len[3*LW +: LW] = LW'(512);
        try_req(3, 513, 0, 1, "R5 oversize rejected");
        try_req(3, 512, 1, 0, "R7 equal length granted, R5 counter untouched");
        tick_n(1);
        cfg_max_len[3*LW +: LW] = LW'(2047);
        try_req(3, 1519, 0, 1, "R6 above ceiling rejected");
        try_req(3, 1518, 1, 0, "R6 ceiling granted");
        tick_n(1);
        req_len[0 +: LW] = LW'(60);
        req_len[3*LW +: LW] = LW'(1600);
        req_valid = 4'b1001;
        #1;
        check_eq("R5 concurrent grant", int'(grant_valid), 1);
        check_eq("R5 concurrent link", int'(grant_link), 0);
        check_eq("R5 concurrent reject mask", int'(reject), 8);
        @(negedge clk);
        req_valid = '0;
        tick_n(2);
    endtask

    task automatic t_round_robin;
        cfg_gap = '0;
        try_req(1, 64, 1, 0, "R8 seed grant link1");
        tick_n(1);
        for (int k = 0; k < NL; k++) req_len[k*LW +: LW] = LW'(64);
        req_valid = 4'b1111;
        for (int k = 0; k < NL; k++) begin
            #1;
            check_eq("R8 rr valid", int'(grant_valid), 1);
            check_eq("R8 rr order", int'(grant_link), (2 + k) % NL);
            @(negedge clk);
        end
        #1;
        check_eq("R11 no grant when all spaced", int'(grant_valid), 0);
        @(negedge clk);
        req_valid = '0;
        tick_n(1);
    endtask

    initial begin
        for (int k = 0; k < NL; k++) cfg_max_len[k*LW +: LW] = LW'(1518);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gap_basic();
        t_gap_extremes();
        t_tick_collide();
        t_cfg_change();
        t_length();
        t_round_robin();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule